// File: doc/BRIEF.md
# Doorbell Vector Capture and Pending-Status Controller

This block watches the stream of inbound memory writes that arrive from the PCIe side of a root-port bridge. Software programs a 64-bit doorbell address. When an inbound write lands on exactly that address, the block reads the vector number from the write data and records it as pending in a 64-entry status array. The array is split into two banks of 32 vectors. Each bank has its own enable mask and its own level interrupt line toward the processor.

Software reaches the block through a simple 32-bit register port. A register write completes in one clock. Read data is returned combinationally for the offset presented. The handler reads a status word, services the vectors that are set, and writes ones to clear them. The interrupt line stays high until no pending vector in that bank is still enabled.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset, the control, doorbell-address, status and mask registers all read zero, and both `irq_lo` and `irq_hi` are low.
- R2: Offset 0x300 always reads 0x0000_0001 (bit 0 = capture function present), and writes to it have no effect. Any offset that is not listed in R2 to R7 reads zero.
- R3: The control word at 0x308 has bit 0 = capture enable and bit 15 = status-record enable. The two bits are written independently and read back, and all other bits read zero. An inbound write is recorded only while both bits are 1.
- R4: The doorbell address is the low word at 0x310 concatenated with the high word at 0x314. A write is recorded only when its 64-bit address equals this value exactly.
- R5: A recorded write with data value v < 64 sets status bit v. Vectors 0..31 appear at 0x440 bit v, and vectors 32..63 appear at 0x444 bit v-32. A data value of 64 or more, including values with any bit above bit 5 set, changes no status bit.
- R6: Writing a word to 0x440 or 0x444 clears exactly the status bits that are 1 in the word and leaves every other bit unchanged.
- R7: The mask words are at 0x448 (low bank) and 0x44C (high bank), where bit = 1 enables that vector. `irq_lo` is high exactly while some low-bank status bit is set together with its mask bit. A pending bit whose mask bit is 0 stays recorded but does not raise the line.
- R8: When a capture and a clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_hi` follows the high bank under the same rule as R7, independent of the low bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mw_valid | input | 1 | Inbound memory write valid |
| mw_addr | input | 64 | Inbound memory write address |
| mw_data | input | 32 | Inbound memory write data |
| irq_lo | output | 1 | Level interrupt for vectors 0..31 |
| irq_hi | output | 1 | Level interrupt for vectors 32..63 |

## Verification
A capture that lands in the wrong bank, or at the wrong bit, shows up in the status word read back on the clock right after the inbound write. It can also show up as the wrong interrupt line rising in that same cycle. A clear that is too wide drops neighbouring pending bits, and this appears in the next status read. A clear that loses the race against a capture leaves a bit at zero that should read one. A fault in gating or address matching leaves a stray status bit set, and that bit stays visible until software clears it.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
   localparam int unsigned REG_AW = 12;
   localparam int unsigned NBANK  = 2;

   localparam logic [REG_AW-1:0] OFS_CAP     = 12'h300;
   localparam logic [REG_AW-1:0] OFS_CTRL    = 12'h308;
   localparam logic [REG_AW-1:0] OFS_BASE_LO = 12'h310;
   localparam logic [REG_AW-1:0] OFS_BASE_HI = 12'h314;
   localparam logic [REG_AW-1:0] OFS_STAT_LO = 12'h440;
   localparam logic [REG_AW-1:0] OFS_MASK_LO = 12'h448;
   localparam int unsigned       BANK_STRIDE = 4;

   localparam int unsigned CTRL_CAP_BIT = 0;
   localparam int unsigned CTRL_REC_BIT = 15;
endpackage

// File: rtl/msi_addr_match.sv
module msi_addr_match #(
   parameter int unsigned MEM_AW  = 64,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_VEC = 64
) (
   input  logic               valid,
   input  logic [MEM_AW-1:0]  addr,
   input  logic [DATA_W-1:0]  data,
   input  logic [MEM_AW-1:0]  base,
   input  logic               cap_en,
   input  logic               rec_en,
   output logic [NUM_VEC-1:0] set_vec
);
   localparam int unsigned VEC_W = $clog2(NUM_VEC);

   generate
      if (NUM_VEC != (1 << VEC_W)) begin : g_bad_vec
         $error("NUM_VEC must be a power of two");
      end
      if (DATA_W <= VEC_W) begin : g_bad_dw
         $error("DATA_W too narrow for vector numbers");
      end
   endgenerate

   logic in_range;
   logic hit;

   always_comb begin
      in_range = (data[DATA_W-1:VEC_W] == '0);
      hit      = valid && cap_en && rec_en && (addr == base) && in_range;
      set_vec  = '0;
      if (hit) set_vec[data[VEC_W-1:0]] = 1'b1;
   end
endmodule

// File: rtl/msi_status_bank.sv
module msi_status_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic         clr_we,
   input  logic         mask_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] status,
   output logic [W-1:0] mask,
   output logic         irq
);
   logic [W-1:0] clr_bits;

   always_comb clr_bits = clr_we ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '0;
      end else begin
         status <= (status & ~clr_bits) | set_vec;
         if (mask_we) mask <= wdata;
      end
   end

   always_comb irq = |(status & mask);

   // R6: a clear with no capture leaves every written-one bit at zero
   a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && set_vec == '0) |=> ((status & $past(wdata)) == '0));

   // R6: bits not written with one are untouched by a clear
   a_r6_w1c_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && set_vec == '0) |=> ((status & ~$past(wdata)) == ($past(status) & ~$past(wdata))));

   // R8: a captured bit is set on the next cycle even under a clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

   // R7: an all-zero mask keeps the line low
   a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq);

   // R7: an enabled capture raises the line on the next cycle
   a_r7_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec & mask) != '0 && !mask_we) |=> irq);
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
   import msi_cap_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned MEM_AW = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              mw_valid,
   input  logic [MEM_AW-1:0] mw_addr,
   input  logic [DATA_W-1:0] mw_data,
   output logic              irq_lo,
   output logic              irq_hi
);
   localparam int unsigned NUM_VEC = NBANK * DATA_W;

   generate
      if (MEM_AW != 2 * DATA_W) begin : g_bad_aw
         $error("MEM_AW must be twice DATA_W");
      end
      if (DATA_W <= CTRL_REC_BIT) begin : g_bad_ctrl
         $error("DATA_W too narrow for control bits");
      end
   endgenerate

   logic              cap_en, rec_en;
   logic [DATA_W-1:0] base_lo, base_hi;
   logic [NUM_VEC-1:0] set_vec;
   logic [DATA_W-1:0] stat_q [NBANK];
   logic [DATA_W-1:0] mask_q [NBANK];
   logic [NBANK-1:0]  irq_b;
   logic [NBANK-1:0]  stat_we, mask_we;
   logic [NUM_VEC-1:0] status_all;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_en  <= 1'b0;
         rec_en  <= 1'b0;
         base_lo <= '0;
         base_hi <= '0;
      end else if (reg_we) begin
         unique case (reg_addr)
            OFS_CTRL: begin
               cap_en <= reg_wdata[CTRL_CAP_BIT];
               rec_en <= reg_wdata[CTRL_REC_BIT];
            end
            OFS_BASE_LO: base_lo <= reg_wdata;
            OFS_BASE_HI: base_hi <= reg_wdata;
            default: ;
         endcase
      end
   end

   msi_addr_match #(.MEM_AW(MEM_AW), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC)) u_match (
      .valid   (mw_valid),
      .addr    (mw_addr),
      .data    (mw_data),
      .base    ({base_hi, base_lo}),
      .cap_en  (cap_en),
      .rec_en  (rec_en),
      .set_vec (set_vec)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam logic [REG_AW-1:0] SOFS = OFS_STAT_LO + REG_AW'(b * BANK_STRIDE);
      localparam logic [REG_AW-1:0] MOFS = OFS_MASK_LO + REG_AW'(b * BANK_STRIDE);
      assign stat_we[b] = reg_we && (reg_addr == SOFS);
      assign mask_we[b] = reg_we && (reg_addr == MOFS);
      assign status_all[b*DATA_W +: DATA_W] = stat_q[b];
      msi_status_bank #(.W(DATA_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_vec (set_vec[b*DATA_W +: DATA_W]),
         .clr_we  (stat_we[b]),
         .mask_we (mask_we[b]),
         .wdata   (reg_wdata),
         .status  (stat_q[b]),
         .mask    (mask_q[b]),
         .irq     (irq_b[b])
      );
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFS_CAP:     reg_rdata = DATA_W'(1);
         OFS_CTRL: begin
            reg_rdata[CTRL_CAP_BIT] = cap_en;
            reg_rdata[CTRL_REC_BIT] = rec_en;
         end
         OFS_BASE_LO: reg_rdata = base_lo;
         OFS_BASE_HI: reg_rdata = base_hi;
         OFS_STAT_LO: reg_rdata = stat_q[0];
         OFS_STAT_LO + REG_AW'(BANK_STRIDE): reg_rdata = stat_q[1];
         OFS_MASK_LO: reg_rdata = mask_q[0];
         OFS_MASK_LO + REG_AW'(BANK_STRIDE): reg_rdata = mask_q[1];
         default: reg_rdata = '0;
      endcase
   end

   assign irq_lo = irq_b[0];
   assign irq_hi = irq_b[1];

   // R3: with either enable low, an inbound write leaves status untouched
   a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_valid && !(cap_en && rec_en) && stat_we == '0) |=> $stable(status_all));

   // R4: a write off the doorbell address leaves status untouched
   a_r4_addr_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_valid && mw_addr != {base_hi, base_lo} && stat_we == '0) |=> $stable(status_all));

   // R5: at most one vector is captured per inbound write
   a_r5_one_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we == '0) |=> ($countones(status_all ^ $past(status_all)) <= 1));
endmodule

// File: tb/tb_msi_capture_ctrl.sv
module tb_msi_capture_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mw_valid = 1'b0;
   logic [63:0] mw_addr = '0;
   logic [31:0] mw_data = '0;
   logic        irq_lo, irq_hi;

   int total = 0;
   int bad = 0;
   bit done = 0;

   localparam logic [63:0] DB = 64'h0000_0001_FEE0_0000;

   // {address, data, expected low status, expected high status}, cumulative
   localparam logic [159:0] TBL [9] = '{
      {DB,                 32'd3,        32'h0000_0008, 32'h0000_0000},
      {DB,                 32'd40,       32'h0000_0008, 32'h0000_0100},
      {DB,                 32'd64,       32'h0000_0008, 32'h0000_0100},
      {DB,                 32'h0000_0103,32'h0000_0008, 32'h0000_0100},
      {DB + 64'd4,         32'd5,        32'h0000_0008, 32'h0000_0100},
      {DB ^ 64'h1_0000_0000, 32'd6,      32'h0000_0008, 32'h0000_0100},
      {DB,                 32'd31,       32'h8000_0008, 32'h0000_0100},
      {DB,                 32'd63,       32'h8000_0008, 32'h8000_0100},
      {DB,                 32'd0,        32'h8000_0009, 32'h8000_0100}
   };

   msi_capture_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mw_valid(mw_valid),
      .mw_addr(mw_addr), .mw_data(mw_data), .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic mw(input logic [63:0] a, input logic [31:0] d);
      @(negedge clk);
      mw_valid = 1'b1; mw_addr = a; mw_data = d;
      @(negedge clk);
      mw_valid = 1'b0;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(12'h308, v); chk("R1 ctrl", v, 0);
      rd(12'h310, v); chk("R1 base_lo", v, 0);
      rd(12'h440, v); chk("R1 stat_lo", v, 0);
      rd(12'h44C, v); chk("R1 mask_hi", v, 0);
      chk("R1 irqs", {30'd0, irq_hi, irq_lo}, 0);
      // R2 capability and unmapped offset
      rd(12'h300, v); chk("R2 cap", v, 1);
      wr(12'h300, 32'h0); rd(12'h300, v); chk("R2 cap write ignored", v, 1);
      rd(12'h304, v); chk("R2 unmapped", v, 0);
      // R4 doorbell address
      wr(12'h310, DB[31:0]); wr(12'h314, DB[63:32]);
      rd(12'h314, v); chk("R4 base_hi", v, DB[63:32]);
      // R3 capture gated while only one enable is set
      wr(12'h308, 32'h0000_0001);
      mw(DB, 32'd7);
      rd(12'h440, v); chk("R3 cap only no record", v, 0);
      wr(12'h308, 32'hFFFF_7FFF);
      rd(12'h308, v); chk("R3 ctrl readback", v, 32'h1);
      wr(12'h308, 32'h0000_8000);
      mw(DB, 32'd7);
      rd(12'h440, v); chk("R3 record only no cap", v, 0);
      wr(12'h308, 32'h0000_8001);
      rd(12'h308, v); chk("R3 ctrl both", v, 32'h8001);
      // R5 table walk, masks still zero
      foreach (TBL[i]) begin
         mw(TBL[i][159:96], TBL[i][95:64]);
         rd(12'h440, v); chk($sformatf("R5 row%0d lo", i), v, TBL[i][63:32]);
         rd(12'h444, v); chk($sformatf("R5 row%0d hi", i), v, TBL[i][31:0]);
      end
      // R7 / R9: masked pending bits keep lines low
      chk("R7 masked low", {31'd0, irq_lo}, 0);
      chk("R9 masked high", {31'd0, irq_hi}, 0);
      wr(12'h448, 32'h0000_0008);
      chk("R7 irq_lo on", {31'd0, irq_lo}, 1);
      chk("R9 irq_hi independent", {31'd0, irq_hi}, 0);
      wr(12'h44C, 32'h8000_0000);
      chk("R9 irq_hi on", {31'd0, irq_hi}, 1);
      // R6 W1C
      wr(12'h440, 32'h0000_0008);
      rd(12'h440, v); chk("R6 clear bit3", v, 32'h8000_0001);
      chk("R7 irq_lo drops", {31'd0, irq_lo}, 0);
      wr(12'h444, 32'h0000_0100);
      rd(12'h444, v); chk("R6 clear hi keeps", v, 32'h8000_0000);
      chk("R9 still high", {31'd0, irq_hi}, 1);
      // R8 capture and clear same bit same cycle
      @(negedge clk);
      mw_valid = 1'b1; mw_addr = DB; mw_data = 32'd3;
      reg_we = 1'b1; reg_addr = 12'h440; reg_wdata = 32'h0000_0009;
      @(negedge clk);
      mw_valid = 1'b0; reg_we = 1'b0;
      rd(12'h440, v); chk("R8 set wins", v, 32'h8000_0008);
      chk("R8 irq_lo", {31'd0, irq_lo}, 1);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule